// File: doc/BRIEF.md
# Byte-Wide UV-Erasable Read-Only Memory Model

This block is a synthesizable behavioural model of a byte-wide, UV-erasable programmable read-only memory together with the logic behind its control pins. The address width is a parameter. The full part is 32K x 8 (`ADDR_W` = 15). The default is a smaller array so that elaboration stays light. All control pins are sampled on the system clock. A mode decoder turns the active-low chip-select/program line, the active-low output-enable line and two flags into one of seven operating modes:
- read
- output disable
- standby
- program
- program inhibit
- program verify
- identification read

The first flag reports that programming voltage is present. The second reports a high voltage on the identification address pin.

A sequencer owns the array. Its states are `ST_ERASE`, `ST_IDLE` and `ST_ARMED`, with these transitions:
- Reset enters `ST_ERASE`.
- `ST_ERASE` goes to `ST_IDLE` once the last address is written.
- `ST_IDLE` goes to `ST_ERASE` when a bulk erase is requested.
- `ST_IDLE` goes to `ST_ARMED` when a program mode is sampled.
- `ST_ARMED` stays in `ST_ARMED` while the program mode holds. Each cycle it recaptures the address and the data.
- `ST_ARMED` goes to `ST_IDLE`, and commits the byte, when chip-select rises with programming voltage still present.
- `ST_ARMED` goes to `ST_IDLE` without writing on any other mode.
- `ST_ARMED` goes to `ST_ERASE` when a bulk erase is requested.

Programming can only clear bits, because a committed byte is the old byte ANDed with the applied data. Only the bulk-erase sweep returns bytes to all ones. It writes 0xFF into one location per clock while `busy` is high.

A registered output stage drives the data bus and a drive-enable flag for an external tri-state buffer. When the identification flag is set, the output stage substitutes fixed manufacturer and device codes for the array contents.

Top module: `eprom_model`

## Requirements
- R1: While reset is held and for DEPTH clock edges after it is released, `busy` is high and the array is swept to 0xFF. At the first sample after that, `busy` is low and every byte reads 0xFF.
- R2: Read mode is chip-select low, output-enable low, programming flag low and identification flag low. Once the edge after such a setup has passed, `dq_oe` is 1 and `dq_out` equals the stored byte at `addr_i`.
- R3: Standby is chip-select high, with programming voltage absent. At the edge after any sample with chip-select high, `dq_oe` goes to 0 and `dq_out` to 0x00, whatever output-enable is.
- R4: Output disable is chip-select low, output-enable high and no programming voltage. It gives `dq_oe` = 0 and `dq_out` = 0x00 one edge later.
- R5: A committed program pulse stores the old byte ANDed with `din_i`. Programming 1s over a 0 leaves the 0 in place.
- R6: A byte is committed only at the edge where chip-select is first sampled high after a low pulse, with programming voltage still present. If output-enable is sampled low, or programming voltage is sampled absent, before chip-select rises, nothing is written.
- R7: With programming voltage present and chip-select held high (program inhibit), no byte changes and the outputs stay undriven.
- R8: Program verify is chip-select low, output-enable low and programming voltage present. It returns the stored byte exactly as a read does.
- R9: With the identification flag set, chip-select low and output-enable low, `dq_out` is 0x8F when `addr_i[0]` is 0 and 0x04 when it is 1. The other address bits have no effect.
- R10: A one-cycle `erase_go` sampled while not erasing raises `busy` at the next edge. `busy` then stays high for DEPTH cycles, after which every byte reads 0xFF.
- R11: While `busy` is high, `dq_oe` is 0 from the following edge on, even with chip-select and output-enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high; starts a blank sweep |
| addr_i | input | ADDR_W | Byte address |
| din_i | input | DATA_W | Data to program |
| ce_pgm_n | input | 1 | Chip select / program pulse, active low |
| oe_n | input | 1 | Output enable, active low |
| vpp_on | input | 1 | Programming voltage present |
| id_hv | input | 1 | High voltage on identification address pin |
| erase_go | input | 1 | Bulk erase request |
| dq_out | output | DATA_W | Registered output data |
| dq_oe | output | 1 | Drive enable for the data bus tri-state |
| busy | output | 1 | Erase sweep in progress |

## Verification
Read, verify, identification and the two high-impedance results all come through one output register. Each is therefore due exactly one clock edge after the pins are set. The driver sets pins on a falling edge and queues the expected value stamped with the next cycle number, and the monitor compares it on the following falling edge. A program commit lands at the edge where chip-select is sampled high, so the read that follows it sees the new byte. The erase duration is measured by counting the falling edges on which `busy` is high: DEPTH from reset release, and DEPTH+1 from an `erase_go` request, including the request edge.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

    typedef enum logic [2:0] {
        M_STANDBY,
        M_OUT_DIS,
        M_READ,
        M_VERIFY,
        M_ID_READ,
        M_PROGRAM,
        M_INHIBIT
    } pin_mode_t;

    typedef enum logic [1:0] {
        ST_ERASE,
        ST_IDLE,
        ST_ARMED
    } seq_state_t;

endpackage

// File: rtl/eprom_mode_decode.sv
module eprom_mode_decode
    import eprom_pkg::*;
(
    input  logic      ce_pgm_n,
    input  logic      oe_n,
    input  logic      vpp_on,
    input  logic      id_hv,
    output pin_mode_t mode
);

    always_comb begin
        if (ce_pgm_n) begin
            mode = vpp_on ? M_INHIBIT : M_STANDBY;
        end else if (!oe_n) begin
            if (id_hv)       mode = M_ID_READ;
            else if (vpp_on) mode = M_VERIFY;
            else             mode = M_READ;
        end else begin
            mode = vpp_on ? M_PROGRAM : M_OUT_DIS;
        end
    end

endmodule

// File: rtl/eprom_array.sv
module eprom_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic              wand_mode,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // A program write can only clear bits; an erase write replaces the byte.
    always_ff @(posedge clk) begin
        if (we) begin
            if (wand_mode) cells[waddr] <= cells[waddr] & wdata;
            else           cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/eprom_seq.sv
module eprom_seq
    import eprom_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  pin_mode_t         mode,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              erase_go,
    output logic              we,
    output logic              wand_mode,
    output logic [ADDR_W-1:0] waddr,
    output logic [DATA_W-1:0] wdata,
    output logic              busy
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    seq_state_t        state, state_nxt;
    logic [ADDR_W-1:0] sweep_cnt;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_ERASE;
        else     state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_ERASE: begin
                if (sweep_cnt == LAST_ADDR) state_nxt = ST_IDLE;
            end
            ST_IDLE: begin
                if (erase_go)                state_nxt = ST_ERASE;
                else if (mode == M_PROGRAM)  state_nxt = ST_ARMED;
            end
            ST_ARMED: begin
                if (erase_go)                state_nxt = ST_ERASE;
                else if (mode != M_PROGRAM)  state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        we        = 1'b0;
        wand_mode = 1'b0;
        waddr     = cap_addr;
        wdata     = cap_data;
        busy      = 1'b0;
        unique case (state)
            ST_ERASE: begin
                we    = 1'b1;
                waddr = sweep_cnt;
                wdata = {DATA_W{1'b1}};
                busy  = 1'b1;
            end
            ST_IDLE: ;
            ST_ARMED: begin
                // chip select rose while programming voltage held: commit
                if (!erase_go && mode == M_INHIBIT) begin
                    we        = 1'b1;
                    wand_mode = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || state != ST_ERASE) sweep_cnt <= '0;
        else                          sweep_cnt <= sweep_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_addr <= '0;
            cap_data <= '0;
        end else if (mode == M_PROGRAM && state != ST_ERASE) begin
            cap_addr <= addr_i;
            cap_data <= din_i;
        end
    end

endmodule

// File: rtl/eprom_out_stage.sv
module eprom_out_stage
    import eprom_pkg::*;
#(
    parameter int          DATA_W   = 8,
    parameter logic [7:0]  MFR_CODE = 8'h8F,
    parameter logic [7:0]  DEV_CODE = 8'h04
) (
    input  logic              clk,
    input  logic              rst,
    input  pin_mode_t         mode,
    input  logic              busy,
    input  logic              addr_lsb,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    logic              drive;
    logic [DATA_W-1:0] id_byte;

    assign id_byte = addr_lsb ? DATA_W'(DEV_CODE) : DATA_W'(MFR_CODE);

    always_comb begin
        unique case (mode)
            M_READ, M_VERIFY, M_ID_READ: drive = !busy;
            default:                     drive = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dq_oe  <= 1'b0;
            dq_out <= '0;
        end else begin
            dq_oe <= drive;
            if (!drive)                dq_out <= '0;
            else if (mode == M_ID_READ) dq_out <= id_byte;
            else                       dq_out <= rdata;
        end
    end

endmodule

// File: rtl/eprom_model.sv
module eprom_model
    import eprom_pkg::*;
#(
    parameter int          ADDR_W   = 10,
    parameter int          DATA_W   = 8,
    parameter logic [7:0]  MFR_CODE = 8'h8F,
    parameter logic [7:0]  DEV_CODE = 8'h04
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              ce_pgm_n,
    input  logic              oe_n,
    input  logic              vpp_on,
    input  logic              id_hv,
    input  logic              erase_go,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              busy
);

    pin_mode_t         mode;
    logic              we;
    logic              wand_mode;
    logic [ADDR_W-1:0] waddr;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rdata;

    eprom_mode_decode u_decode (
        .ce_pgm_n (ce_pgm_n),
        .oe_n     (oe_n),
        .vpp_on   (vpp_on),
        .id_hv    (id_hv),
        .mode     (mode)
    );

    eprom_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .addr_i    (addr_i),
        .din_i     (din_i),
        .erase_go  (erase_go),
        .we        (we),
        .wand_mode (wand_mode),
        .waddr     (waddr),
        .wdata     (wdata),
        .busy      (busy)
    );

    eprom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk       (clk),
        .we        (we),
        .wand_mode (wand_mode),
        .waddr     (waddr),
        .wdata     (wdata),
        .raddr     (addr_i),
        .rdata     (rdata)
    );

    eprom_out_stage #(.DATA_W(DATA_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_out (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .busy     (busy),
        .addr_lsb (addr_i[0]),
        .rdata    (rdata),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe)
    );

endmodule

// File: rtl/eprom_model_chk.sv
module eprom_model_chk #(
    parameter int          ADDR_W   = 10,
    parameter int          DATA_W   = 8,
    parameter logic [7:0]  MFR_CODE = 8'h8F,
    parameter logic [7:0]  DEV_CODE = 8'h04
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr_i,
    input logic              ce_pgm_n,
    input logic              oe_n,
    input logic              id_hv,
    input logic [DATA_W-1:0] dq_out,
    input logic              dq_oe,
    input logic              busy
);

    localparam int DEPTH = 1 << ADDR_W;

    logic        past_ok;
    int unsigned busy_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            past_ok  <= 1'b0;
            busy_run <= 0;
        end else begin
            past_ok  <= 1'b1;
            busy_run <= busy ? busy_run + 1 : 0;
        end
    end

    // R3
    standby_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(ce_pgm_n)) |-> (!dq_oe && dq_out == '0));

    // R4
    out_dis_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(!ce_pgm_n && oe_n)) |-> !dq_oe);

    // R9
    id_code_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(id_hv && !ce_pgm_n && !oe_n && !busy))
        |-> (dq_oe && dq_out == ($past(addr_i[0]) ? DATA_W'(DEV_CODE) : DATA_W'(MFR_CODE))));

    // R11
    busy_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(busy)) |-> !dq_oe);

    // R10
    erase_len_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_run < DEPTH));

endmodule

bind eprom_model eprom_model_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
) i_chk (
    .clk      (clk),
    .rst      (rst),
    .addr_i   (addr_i),
    .ce_pgm_n (ce_pgm_n),
    .oe_n     (oe_n),
    .id_hv    (id_hv),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe),
    .busy     (busy)
);

// File: tb/test_eprom_model.sv
`timescale 1ns/1ps
module test_eprom_model;

    localparam int AW    = 10;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] din_i = '0;
    logic          ce_pgm_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          vpp_on = 1'b0;
    logic          id_hv = 1'b0;
    logic          erase_go = 1'b0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;
    logic          busy;

    eprom_model #(.ADDR_W(AW), .DATA_W(DW)) i_eprom_model (
        .clk(clk), .rst(rst), .addr_i(addr_i), .din_i(din_i),
        .ce_pgm_n(ce_pgm_n), .oe_n(oe_n), .vpp_on(vpp_on), .id_hv(id_hv),
        .erase_go(erase_go), .dq_out(dq_out), .dq_oe(dq_oe), .busy(busy)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int          due;
        logic        oe;
        logic [7:0]  dq;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [7:0]  model [DEPTH];
    int          cyc = 0;
    int          total = 0;
    int          bad = 0;
    bit          done = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: run hung, actual cycle=%0d expected below 150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops scoreboard items when they fall due
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            e = sb.pop_front();
            check(dq_oe == e.oe, {e.tag, " oe"}, dq_oe, e.oe);
            check(dq_out == e.dq, {e.tag, " dq"}, dq_out, e.dq);
        end
    end

    task automatic park();
        @(negedge clk);
        ce_pgm_n = 1'b1; oe_n = 1'b1; vpp_on = 1'b0; id_hv = 1'b0; erase_go = 1'b0;
    endtask

    task automatic read_exp(input logic [AW-1:0] a, input bit vpp, input bit id, input string tag);
        exp_t e;
        @(negedge clk);
        addr_i = a; ce_pgm_n = 1'b0; oe_n = 1'b0; vpp_on = vpp; id_hv = id;
        e.due = cyc + 1;
        e.oe  = 1'b1;
        e.dq  = id ? (a[0] ? 8'h04 : 8'h8F) : model[a];
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic hiz_exp(input bit ce, input bit oe, input bit vpp, input string tag);
        exp_t e;
        @(negedge clk);
        ce_pgm_n = ce; oe_n = oe; vpp_on = vpp; id_hv = 1'b0;
        e.due = cyc + 1; e.oe = 1'b0; e.dq = 8'h00; e.tag = tag;
        sb.push_back(e);
    endtask

    // kind 0: clean pulse; 1: vpp drops before release; 2: oe falls before release
    task automatic prog(input logic [AW-1:0] a, input logic [7:0] d, input int kind);
        @(negedge clk);
        addr_i = a; din_i = d; vpp_on = 1'b1; oe_n = 1'b1; ce_pgm_n = 1'b1; id_hv = 1'b0;
        @(negedge clk); ce_pgm_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        if (kind == 1) vpp_on = 1'b0;
        if (kind == 2) oe_n = 1'b0;
        @(negedge clk); ce_pgm_n = 1'b1;
        @(negedge clk); vpp_on = 1'b0; oe_n = 1'b1;
        if (kind == 0) model[a] = model[a] & d;
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "scoreboard drained", sb.size(), 0);
    endtask

    initial begin
        int n;
        bit leak;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        // R1: busy during reset, then DEPTH edges of sweep
        check(busy == 1'b1 && dq_oe == 1'b0, "R1 busy in reset", busy, 1);
        rst = 1'b0;
        n = 0;
        while (1) begin
            @(negedge clk); n++;
            if (!busy || n > 4 * DEPTH) break;
        end
        check(n == DEPTH, "R1 sweep length", n, DEPTH);
        read_exp(10'h000, 0, 0, "R1 blank low");
        read_exp(10'h3FF, 0, 0, "R1 blank high");
        // R3 standby with oe low and high; R4 output disable
        hiz_exp(1, 0, 0, "R3 standby oe low");
        hiz_exp(1, 1, 0, "R3 standby oe high");
        hiz_exp(0, 1, 0, "R4 output disable");
        drain();
        // R5 AND semantics, R2 read
        prog(10'h005, 8'hA5, 0);
        read_exp(10'h005, 0, 0, "R2 read programmed");
        read_exp(10'h006, 0, 0, "R2 neighbour untouched");
        prog(10'h005, 8'h3C, 0);
        read_exp(10'h005, 0, 0, "R5 and of two pulses");
        prog(10'h005, 8'hFF, 0);
        read_exp(10'h005, 0, 0, "R5 ones do not restore");
        // R8 verify with vpp present
        prog(10'h2F0, 8'h5A, 0);
        read_exp(10'h2F0, 1, 0, "R8 verify");
        drain();
        // R6 aborted pulses write nothing
        prog(10'h100, 8'h00, 1);
        read_exp(10'h100, 0, 0, "R6 vpp dropped");
        prog(10'h101, 8'h00, 2);
        read_exp(10'h101, 0, 0, "R6 oe fell");
        // R7 inhibit: vpp present, ce high, data applied
        @(negedge clk);
        addr_i = 10'h102; din_i = 8'h00;
        hiz_exp(1, 1, 1, "R7 inhibit hi-z");
        hiz_exp(1, 1, 1, "R7 inhibit hold");
        park();
        read_exp(10'h102, 0, 0, "R7 inhibit no write");
        // R9 identification codes, other bits varied
        read_exp(10'h2A6, 0, 1, "R9 manufacturer code");
        read_exp(10'h155, 0, 1, "R9 device code");
        read_exp(10'h001, 1, 1, "R9 device code vpp");
        drain();
        // R10 bulk erase, R11 outputs quiet while busy
        @(negedge clk);
        addr_i = 10'h005; ce_pgm_n = 1'b0; oe_n = 1'b0; vpp_on = 1'b0; id_hv = 1'b0;
        erase_go = 1'b1;
        n = 0; leak = 0;
        while (1) begin
            @(negedge clk); erase_go = 1'b0; n++;
            if (busy && n > 1 && dq_oe) leak = 1;
            if (!busy || n > 4 * DEPTH) break;
        end
        check(n == DEPTH + 1, "R10 erase length", n, DEPTH + 1);
        check(!leak, "R11 no drive while busy", leak, 0);
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        park();
        read_exp(10'h005, 0, 0, "R10 erased byte");
        read_exp(10'h2F0, 0, 0, "R10 erased byte 2");
        read_exp(10'h3FF, 0, 0, "R10 erased top");
        drain();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule